// File: doc/BRIEF.md
# Host Indirect Memory Access Port

This block is a slave port that gives an external host access to a processor's internal program memory (24-bit words) and data memory (16-bit words) over a 16-bit bus. The host first runs an address-latch cycle that loads a start address and a memory-select bit into the port's pointer. It then runs read or write data cycles. The pointer advances by one after each complete word. A program word is moved in two host cycles and is written to memory as a single 24-bit write once the second half arrives.

The processor core shares both memories with the port. A core request for a memory takes that memory in the same clock, and a host cycle that needs the memory waits on the acknowledge line until the core releases it. The core can also load the port pointer directly. A host latch or a core pointer load that falls between the two halves of a program word drops the half-finished transfer. The top 32 data-memory addresses hold memory-mapped control registers, and the port can never read or change them.

Top module: `hip_port`

## Requirements
- R1: An address-latch cycle (h_req_i and h_alatch_i high) is acknowledged in the same clock, with no memory access. It loads the pointer from h_wdata_i: bits [13:0] are the address, and bit 14 selects the memory (0 = program, 1 = data).
- R2: With data memory selected, each data cycle reads or writes one 16-bit word at the pointer, and the pointer then advances by one, wrapping at 14 bits.
- R3: A program-memory write takes two host writes. The first carries word bits [23:8] and the second carries bits [7:0] in h_wdata_i[7:0]. Memory is written once, with all 24 bits, only when the second half completes, and the pointer advances by one after it.
- R4: A program-memory read takes two host reads. The first returns word bits [23:8]. The second returns bits [7:0] zero-extended, taken from the word as it stood at the first half. The pointer advances by one after the second half.
- R5: A host address latch between the two halves of a program-word read or write cancels the remaining half, leaves memory unchanged, and makes the next cycle start a new word at the newly latched address.
- R6: A core pointer load (core_ctl_we_i, same bit encoding as R1) cancels any half-finished program word in the same way. If it coincides with a host latch, the core value is the one kept.
- R7: A host data cycle to data addresses 0x3FE0–0x3FFF is acknowledged without waiting for memory, even while the core holds data memory. A read returns 0x0000, a write leaves memory unchanged, and the pointer still advances.
- R8: prot_err_o goes high after any host data cycle to the protected window and stays high until reset.
- R9: While the core requests a memory, that memory's ports carry the core's access, and a host cycle that needs that memory holds h_ack_o low until the request drops. A first-half program write needs no memory and is not stalled.
- R10: After reset the pointer is address 0 in program memory, no half word is pending, and prot_err_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_req_i | input | 1 | Host cycle request, held until acknowledged |
| h_alatch_i | input | 1 | Host cycle is an address latch |
| h_we_i | input | 1 | Host data cycle is a write |
| h_wdata_i | input | 16 | Host write data or latch value |
| h_rdata_o | output | 16 | Host read data, valid while h_ack_o is high |
| h_ack_o | output | 1 | Host cycle completes at this clock edge |
| core_ctl_we_i | input | 1 | Core loads the port pointer |
| core_ctl_wdata_i | input | 15 | Core pointer value: select bit 14, address [13:0] |
| core_pm_req_i | input | 1 | Core claims program memory |
| core_pm_we_i | input | 1 | Core program-memory write |
| core_pm_addr_i | input | 14 | Core program-memory address |
| core_pm_wdata_i | input | 24 | Core program-memory write data |
| core_dm_req_i | input | 1 | Core claims data memory |
| core_dm_we_i | input | 1 | Core data-memory write |
| core_dm_addr_i | input | 14 | Core data-memory address |
| core_dm_wdata_i | input | 16 | Core data-memory write data |
| pm_addr_o | output | 14 | Program memory address |
| pm_we_o | output | 1 | Program memory write enable |
| pm_wdata_o | output | 24 | Program memory write data |
| pm_rdata_i | input | 24 | Program memory read data (asynchronous) |
| dm_addr_o | output | 14 | Data memory address |
| dm_we_o | output | 1 | Data memory write enable |
| dm_wdata_o | output | 16 | Data memory write data |
| dm_rdata_i | input | 16 | Data memory read data (asynchronous) |
| prot_err_o | output | 1 | Sticky flag: host touched the protected window |

## Verification
Assertions check several rules on every clock. No host-driven data-memory write lands in the protected window. Program memory is written only on a second half. The error flag never falls. A host cycle that needs a memory the core holds is never acknowledged. Pointer loads clear the pending half, and data cycles step the pointer. The end-to-end results need the bench's scenarios, because they depend on memory contents. These include the 24-bit assembly and split order, the snapshot read of the low byte, the old word surviving an aborted write, and the next access landing at the new address. They also include zero reads and unchanged memory behind the window, and the wrap of the pointer past 0x3FFF.

// File: rtl/hip_pkg.sv
package hip_pkg;
  localparam int unsigned HIP_AW = 14;
  localparam int unsigned HIP_HW = 16;
  localparam int unsigned HIP_PW = 24;
  localparam int unsigned HIP_WB = 5;  // protected window = top 2**WB data addresses

  typedef enum logic {
    MSEL_PM = 1'b0,
    MSEL_DM = 1'b1
  } msel_e;
endpackage

// File: rtl/hip_ctl.sv
module hip_ctl
  import hip_pkg::*;
#(
  parameter int unsigned AW = HIP_AW,
  parameter int unsigned HW = HIP_HW,
  parameter int unsigned PW = HIP_PW,
  localparam int unsigned LW = PW - HW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          core_we_i,
  input  logic [AW:0]   core_wdata_i,
  input  logic          lat_i,
  input  logic          dat_i,
  input  logic          we_i,
  input  logic [HW-1:0] wdata_i,
  input  logic [LW-1:0] pm_low_i,
  output logic [AW-1:0] addr_o,
  output msel_e         msel_o,
  output logic          half_o,
  output logic [HW-1:0] hold_o
);
  logic [AW-1:0] addr_q;
  msel_e         msel_q;
  logic          half_q;
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      msel_q <= MSEL_PM;
      half_q <= 1'b0;
      hold_q <= '0;
    end else begin
      if (core_we_i) begin
        addr_q <= core_wdata_i[AW-1:0];
        msel_q <= msel_e'(core_wdata_i[AW]);
        half_q <= 1'b0;
      end else if (lat_i) begin
        addr_q <= wdata_i[AW-1:0];
        msel_q <= msel_e'(wdata_i[AW]);
        half_q <= 1'b0;
      end else if (dat_i) begin
        if (msel_q == MSEL_DM) begin
          addr_q <= addr_q + 1'b1;
        end else if (!half_q) begin
          half_q <= 1'b1;
          hold_q <= we_i ? wdata_i : HW'(pm_low_i);
        end else begin
          half_q <= 1'b0;
          addr_q <= addr_q + 1'b1;
        end
      end
    end
  end

  assign addr_o = addr_q;
  assign msel_o = msel_q;
  assign half_o = half_q;
  assign hold_o = hold_q;

  a_r6_core_load_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_we_i |=> (!half_o && addr_o == $past(core_wdata_i[AW-1:0])));
  a_r5_latch_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_i && !core_we_i) |=> !half_o);
  a_r2_dm_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_i && msel_o == MSEL_DM && !core_we_i) |=> addr_o == $past(addr_o) + 1'b1);
endmodule

// File: rtl/hip_arb.sv
module hip_arb #(
  parameter int unsigned AW = 14,
  parameter int unsigned DW = 16
) (
  input  logic          core_req_i,
  input  logic          core_we_i,
  input  logic [AW-1:0] core_addr_i,
  input  logic [DW-1:0] core_wdata_i,
  input  logic          host_need_i,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic          host_stall_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o
);
  // core has fixed priority; host waits
  assign host_stall_o = core_req_i & host_need_i;
  assign mem_addr_o   = core_req_i ? core_addr_i  : host_addr_i;
  assign mem_we_o     = core_req_i ? core_we_i    : host_we_i;
  assign mem_wdata_o  = core_req_i ? core_wdata_i : host_wdata_i;
endmodule

// File: rtl/hip_port.sv
module hip_port
  import hip_pkg::*;
#(
  parameter int unsigned AW = HIP_AW,
  parameter int unsigned HW = HIP_HW,
  parameter int unsigned PW = HIP_PW,
  parameter int unsigned WB = HIP_WB,
  localparam int unsigned LW = PW - HW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          h_req_i,
  input  logic          h_alatch_i,
  input  logic          h_we_i,
  input  logic [HW-1:0] h_wdata_i,
  output logic [HW-1:0] h_rdata_o,
  output logic          h_ack_o,
  input  logic          core_ctl_we_i,
  input  logic [AW:0]   core_ctl_wdata_i,
  input  logic          core_pm_req_i,
  input  logic          core_pm_we_i,
  input  logic [AW-1:0] core_pm_addr_i,
  input  logic [PW-1:0] core_pm_wdata_i,
  input  logic          core_dm_req_i,
  input  logic          core_dm_we_i,
  input  logic [AW-1:0] core_dm_addr_i,
  input  logic [HW-1:0] core_dm_wdata_i,
  output logic [AW-1:0] pm_addr_o,
  output logic          pm_we_o,
  output logic [PW-1:0] pm_wdata_o,
  input  logic [PW-1:0] pm_rdata_i,
  output logic [AW-1:0] dm_addr_o,
  output logic          dm_we_o,
  output logic [HW-1:0] dm_wdata_o,
  input  logic [HW-1:0] dm_rdata_i,
  output logic          prot_err_o
);
  logic [AW-1:0] addr;
  msel_e         msel;
  logic          half;
  logic [HW-1:0] hold;
  logic          data_cyc, in_win, need_pm, need_dm;
  logic          stall_pm, stall_dm;
  logic          lat_fire, dat_fire;
  logic          host_pm_we, host_dm_we;
  logic          prot_q;

  assign data_cyc = h_req_i & ~h_alatch_i;
  assign in_win   = (msel == MSEL_DM) && (addr[AW-1:WB] == '1);
  // PM needed for first read half (fetch) and second write half (commit)
  assign need_pm  = data_cyc & (msel == MSEL_PM) & (h_we_i ? half : ~half);
  assign need_dm  = data_cyc & (msel == MSEL_DM) & ~in_win;

  assign h_ack_o  = h_req_i & ~stall_pm & ~stall_dm;
  assign lat_fire = h_ack_o & h_alatch_i;
  assign dat_fire = h_ack_o & ~h_alatch_i;

  assign host_pm_we = dat_fire & (msel == MSEL_PM) & h_we_i & half;
  assign host_dm_we = dat_fire & (msel == MSEL_DM) & h_we_i & ~in_win;

  hip_ctl #(.AW(AW), .HW(HW), .PW(PW)) u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .core_we_i    (core_ctl_we_i),
    .core_wdata_i (core_ctl_wdata_i),
    .lat_i        (lat_fire),
    .dat_i        (dat_fire),
    .we_i         (h_we_i),
    .wdata_i      (h_wdata_i),
    .pm_low_i     (pm_rdata_i[LW-1:0]),
    .addr_o       (addr),
    .msel_o       (msel),
    .half_o       (half),
    .hold_o       (hold)
  );

  hip_arb #(.AW(AW), .DW(PW)) u_arb_pm (
    .core_req_i   (core_pm_req_i),
    .core_we_i    (core_pm_we_i),
    .core_addr_i  (core_pm_addr_i),
    .core_wdata_i (core_pm_wdata_i),
    .host_need_i  (need_pm),
    .host_we_i    (host_pm_we),
    .host_addr_i  (addr),
    .host_wdata_i ({hold, h_wdata_i[LW-1:0]}),
    .host_stall_o (stall_pm),
    .mem_addr_o   (pm_addr_o),
    .mem_we_o     (pm_we_o),
    .mem_wdata_o  (pm_wdata_o)
  );

  hip_arb #(.AW(AW), .DW(HW)) u_arb_dm (
    .core_req_i   (core_dm_req_i),
    .core_we_i    (core_dm_we_i),
    .core_addr_i  (core_dm_addr_i),
    .core_wdata_i (core_dm_wdata_i),
    .host_need_i  (need_dm),
    .host_we_i    (host_dm_we),
    .host_addr_i  (addr),
    .host_wdata_i (h_wdata_i),
    .host_stall_o (stall_dm),
    .mem_addr_o   (dm_addr_o),
    .mem_we_o     (dm_we_o),
    .mem_wdata_o  (dm_wdata_o)
  );

  always_comb begin
    if (h_alatch_i)              h_rdata_o = '0;
    else if (msel == MSEL_DM)    h_rdata_o = in_win ? '0 : dm_rdata_i;
    else if (half)               h_rdata_o = HW'(hold[LW-1:0]);
    else                         h_rdata_o = pm_rdata_i[PW-1:LW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 prot_q <= 1'b0;
    else if (dat_fire && in_win) prot_q <= 1'b1;
  end
  assign prot_err_o = prot_q;

  a_r7_no_window_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dm_we_o && !core_dm_req_i) |-> (dm_addr_o[AW-1:WB] != '1));
  a_r3_commit_on_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_we_o && !core_pm_req_i) |-> half);
  a_r8_sticky_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_err_o |=> prot_err_o);
  a_r9_core_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((core_dm_req_i && need_dm) || (core_pm_req_i && need_pm)) |-> !h_ack_o);
  a_r1_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_ack_o |-> h_req_i);
endmodule

// File: tb/sim_hip_port.sv
module sim_hip_port;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_req = 0, h_alatch = 0, h_we = 0;
  logic [15:0] h_wdata = '0;
  logic [15:0] h_rdata;
  logic        h_ack;
  logic        cctl_we = 0;
  logic [14:0] cctl_wdata = '0;
  logic        cpm_req = 0, cpm_we = 0;
  logic [13:0] cpm_addr = '0;
  logic [23:0] cpm_wdata = '0;
  logic        cdm_req = 0, cdm_we = 0;
  logic [13:0] cdm_addr = '0;
  logic [15:0] cdm_wdata = '0;
  logic [13:0] pm_addr, dm_addr;
  logic        pm_we, dm_we;
  logic [23:0] pm_wdata, pm_rdata;
  logic [15:0] dm_wdata, dm_rdata;
  logic        prot_err;

  logic [23:0] pm_mem [256];
  logic [15:0] dm_mem [256];

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] rd;
  int stalls;

  always #(PERIOD/2) clk = ~clk;

  hip_port u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .h_req_i(h_req), .h_alatch_i(h_alatch), .h_we_i(h_we), .h_wdata_i(h_wdata),
    .h_rdata_o(h_rdata), .h_ack_o(h_ack),
    .core_ctl_we_i(cctl_we), .core_ctl_wdata_i(cctl_wdata),
    .core_pm_req_i(cpm_req), .core_pm_we_i(cpm_we), .core_pm_addr_i(cpm_addr),
    .core_pm_wdata_i(cpm_wdata),
    .core_dm_req_i(cdm_req), .core_dm_we_i(cdm_we), .core_dm_addr_i(cdm_addr),
    .core_dm_wdata_i(cdm_wdata),
    .pm_addr_o(pm_addr), .pm_we_o(pm_we), .pm_wdata_o(pm_wdata), .pm_rdata_i(pm_rdata),
    .dm_addr_o(dm_addr), .dm_we_o(dm_we), .dm_wdata_o(dm_wdata), .dm_rdata_i(dm_rdata),
    .prot_err_o(prot_err)
  );

  assign pm_rdata = pm_mem[pm_addr[7:0]];
  assign dm_rdata = dm_mem[dm_addr[7:0]];
  always @(posedge clk) begin
    if (pm_we) pm_mem[pm_addr[7:0]] <= pm_wdata;
    if (dm_we) dm_mem[dm_addr[7:0]] <= dm_wdata;
  end

  // {latch, we, check, data[15:0], expect[15:0]}
  localparam logic [34:0] VEC [16] = '{
    {3'b100, 16'h4020, 16'h0000},
    {3'b001, 16'h0000, 16'hD020},
    {3'b001, 16'h0000, 16'hD021},
    {3'b010, 16'h1234, 16'h0000},
    {3'b100, 16'h4022, 16'h0000},
    {3'b001, 16'h0000, 16'h1234},
    {3'b100, 16'h0010, 16'h0000},
    {3'b001, 16'h0000, 16'hA000},
    {3'b001, 16'h0000, 16'h0010},
    {3'b001, 16'h0000, 16'hA000},
    {3'b001, 16'h0000, 16'h0011},
    {3'b010, 16'hBEEF, 16'h0000},
    {3'b010, 16'h00C5, 16'h0000},
    {3'b100, 16'h0012, 16'h0000},
    {3'b001, 16'h0000, 16'hBEEF},
    {3'b001, 16'h0000, 16'h00C5}
  };

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_op(input logic lat, input logic we, input logic [15:0] d);
    @(negedge clk);
    h_req = 1; h_alatch = lat; h_we = we; h_wdata = d;
    #1;
    stalls = 0;
    while (!h_ack && stalls < 1000) begin
      @(negedge clk); #1; stalls++;
    end
    rd = h_rdata;
    @(posedge clk); #1;
    h_req = 0; h_alatch = 0; h_we = 0;
  endtask

  task automatic core_load(input logic [14:0] v);
    @(negedge clk);
    cctl_we = 1; cctl_wdata = v;
    @(posedge clk); #1;
    cctl_we = 0;
  endtask

  initial begin
    #(PERIOD*100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      pm_mem[i] = 24'hA00000 | 24'(i);
      dm_mem[i] = 16'hD000 | 16'(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10: reset state
    #1 check("R10 prot_err after reset", 24'(prot_err), 24'h0);
    host_op(0, 0, 0); check("R10 first read PM addr 0 upper", 24'(rd), 24'hA000);
    host_op(0, 0, 0); check("R10 first read PM addr 0 low", 24'(rd), 24'h0000);
    host_op(0, 0, 0); check("R4 pointer stepped to 1", 24'(rd), 24'hA000);
    host_op(0, 0, 0); check("R4 addr 1 low", 24'(rd), 24'h0001);

    for (int i = 0; i < 16; i++) begin
      logic [34:0] v;
      string tag;
      v = VEC[i];
      tag = (i < 6) ? "R2" : (i < 11) ? "R4" : "R3";
      host_op(v[34], v[33], v[31:16]);
      if (v[34]) check("R1 latch acked without stall", 24'(stalls), 24'h0);
      if (v[32]) check($sformatf("%s vector %0d", tag, i), 24'(rd), 24'(v[15:0]));
    end
    check("R3 committed 24-bit word", pm_mem[8'h12], 24'hBEEFC5);

    // R5: host latch between write halves
    host_op(1, 0, 16'h0030);
    host_op(0, 1, 16'h1111);
    host_op(1, 0, 16'h0031);
    host_op(0, 0, 0); check("R5 next access at new addr upper", 24'(rd), 24'hA000);
    host_op(0, 0, 0); check("R5 next access at new addr low", 24'(rd), 24'h0031);
    check("R5 aborted word left memory unchanged", pm_mem[8'h30], 24'hA00030);
    // R5: latch between read halves
    host_op(1, 0, 16'h0033);
    host_op(0, 0, 0);
    host_op(1, 0, 16'h4025);
    host_op(0, 0, 0); check("R5 read abort then DM read", 24'(rd), 24'hD025);

    // R6: core pointer load between write halves
    host_op(1, 0, 16'h0040);
    host_op(0, 1, 16'h2222);
    core_load(15'h4050);
    host_op(0, 0, 0); check("R6 core load redirects to DM 0x50", 24'(rd), 24'hD050);
    check("R6 aborted PM word unchanged", pm_mem[8'h40], 24'hA00040);
    // R6: core load wins over simultaneous host latch
    @(negedge clk);
    cctl_we = 1; cctl_wdata = 15'h4060;
    h_req = 1; h_alatch = 1; h_wdata = 16'h0070;
    #1 check("R1 latch acked with core load", 24'(h_ack), 24'h1);
    @(posedge clk); #1;
    cctl_we = 0; h_req = 0; h_alatch = 0;
    host_op(0, 0, 0); check("R6 core value kept over host latch", 24'(rd), 24'hD060);

    // R7/R8: protected window, no stall even with core on DM
    host_op(1, 0, 16'h7FE5);
    cdm_req = 1; cdm_addr = 14'h0080;
    host_op(0, 0, 0);
    check("R7 window read returns zero", 24'(rd), 24'h0000);
    check("R7 window access not stalled", 24'(stalls), 24'h0);
    cdm_req = 0;
    host_op(0, 1, 16'h9999);
    host_op(0, 0, 0); check("R7 pointer stepped inside window", 24'(rd), 24'h0000);
    host_op(1, 0, 16'h7FFF);
    host_op(0, 0, 0);
    host_op(0, 0, 0); check("R7 pointer wraps past 0x3FFF", 24'(rd), 24'hD000);
    host_op(1, 0, 16'h40E6);
    host_op(0, 0, 0); check("R7 window write ignored", 24'(rd), 24'hD0E6);
    check("R8 prot_err set", 24'(prot_err), 24'h1);
    host_op(0, 0, 0);
    check("R8 prot_err sticky", 24'(prot_err), 24'h1);

    // R9: core wins data memory
    host_op(1, 0, 16'h4024);
    @(negedge clk);
    cdm_req = 1; cdm_addr = 14'h0080;
    h_req = 1;
    #1 check("R9 host stalled by core DM", 24'(h_ack), 24'h0);
    check("R9 DM port carries core address", 24'(dm_addr), 24'h0080);
    repeat (3) @(negedge clk);
    #1 check("R9 still stalled", 24'(h_ack), 24'h0);
    @(negedge clk);
    cdm_req = 0;
    #1 check("R9 ack after release", 24'(h_ack), 24'h1);
    check("R9 read data after release", 24'(h_rdata), 24'hD024);
    @(posedge clk); #1 h_req = 0;

    // R9: first PM write half not stalled, second half stalled
    host_op(1, 0, 16'h0050);
    cpm_req = 1; cpm_addr = 14'h0090;
    host_op(0, 1, 16'h7777);
    check("R9 first half not stalled", 24'(stalls), 24'h0);
    @(negedge clk);
    h_req = 1; h_we = 1; h_wdata = 16'h0033;
    #1 check("R9 commit half stalled by core PM", 24'(h_ack), 24'h0);
    repeat (2) @(negedge clk);
    cpm_req = 0;
    #1 check("R9 commit acked after release", 24'(h_ack), 24'h1);
    @(posedge clk); #1 begin h_req = 0; h_we = 0; end
    check("R3 word written after stall", pm_mem[8'h50], 24'h777733);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule